// File: doc/BRIEF.md
# SPI Input-Status Frame Serializer

This block is the serial reporting side of an eight-channel digital input receiver. It holds a registered copy of eight already-filtered input states. It computes four even-parity check bits over fixed groups of those inputs. When an SPI master pulls chip-select low, the block freezes the input states, the parity bits, an undervoltage flag and an overtemperature flag into a shift register. It then streams that register out most significant bit first, using clock polarity 0 and clock phase 0.

A static mode input chooses between two frame lengths. One is a sixteen-bit frame that carries the eight data bits and eight control bits. The other is an eight-bit frame that carries the data bits only. MOSI is captured on every SCK rising edge and fed into the tail of the shift register, so devices can be chained: once a frame has been fully shifted out, the bits received from upstream follow it on MISO. The block accepts SCK being either low or high when chip-select falls. A supply-loss flag forces every transmitted bit to zero.

All pins are sampled on the system clock `clk`, so SCK must be several times slower than `clk`. The data output, its complement and an output enable are provided separately, and the pad turns them into a tri-state driver.

Top module: `insense_spi_frame`

## Requirements
- R1: On the clock edge that first samples `csN` low after it was high, the frame is captured. From the next clock onward, `misoEn` is 1 and `miso` presents frame bit 15.
- R2: Frame layout, bit 15 first on the wire: bits 15..8 = `inState[7]`..`inState[0]`, bit 7 = NOT `uvAlarm`, bit 6 = NOT `otAlarm`, bit 1 = 0, bit 0 = 1.
- R3: Parity bits are even parity (XOR): bit 5 = XOR of `inState[7:0]`, bit 4 = XOR of `inState[7:4]`, bit 3 = XOR of `inState[3:0]`, bit 2 = XOR of `inState[5:2]`.
- R4: An SCK falling edge advances `miso` by one bit only if an SCK rising edge has been seen since chip-select fell. When SCK is high at chip-select fall, the first falling edge leaves bit 15 in place, and bit 14 appears after the second falling edge.
- R5: With `frameShort` = 0, bit 15-k is on `miso` after k qualified falling edges, for k = 0..15. After 16+j falling edges, `miso` carries the MOSI bit captured on rising edge j+1.
- R6: With `frameShort` = 1, only bits 15..8 are sent. After 8+j qualified falling edges, `miso` carries the MOSI bit captured on rising edge j+1.
- R7: MOSI is sampled only on SCK rising edges while selected, and it reaches nothing except the shift-register tail.
- R8: While `csN` is high, `misoEn` goes to 0 within one clock, and `miso` and `misoN` are both 0.
- R9: While `powerLost` is 1, `miso` is 0 for every bit, including the bit 0 and bit 1 end markers and the passed-through MOSI bits.
- R10: While `misoEn` is 1, `misoN` is the inverse of `miso`.
- R11: Changes on `inState`, `uvAlarm` or `otAlarm` after the frame is captured do not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every pin is sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inState | input | 8 | Filtered input states; bit n-1 is input n |
| uvAlarm | input | 1 | Undervoltage alarm, active high |
| otAlarm | input | 1 | Overtemperature alarm, active high |
| powerLost | input | 1 | Supply-loss flag; forces MISO low |
| frameShort | input | 1 | Static frame-length select: 0 = 16 bits, 1 = 8 bits |
| csN | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | SPI data from master or upstream device |
| miso | output | 1 | SPI data to master |
| misoN | output | 1 | Complement of miso while enabled |
| misoEn | output | 1 | Output enable for the miso and misoN pad drivers |

## Verification
The bench starts one frame with SCK resting high. A design that shifts on any falling edge would skip bit 14 there, and every later sample of that frame would be off by one. Sixteen-bit and eight-bit frames are both run past their end with a MOSI pattern. This exposes a wrong tail position: an eight-bit frame that leaks the control bits, or MOSI bits arriving early or late. The inputs are inverted in the middle of one frame, so a design that tracks them live instead of holding a snapshot sends the wrong data bits. A frame under supply loss expects zeros where the 0/1 end markers would be, which catches a gate that only clears the captured data.

// File: rtl/insense_spi_pkg.sv
package insense_spi_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 8;
  localparam int FRAME_W = DATA_W + CTRL_W;
  localparam int PAR_N   = 4;

  typedef struct packed {
    logic load;       // capture snapshot into shift register
    logic shiftOut;   // advance shift register by one bit
    logic captureIn;  // sample mosi
  } strobeT;
endpackage

// File: rtl/insense_spi_ctrl.sv
module insense_spi_ctrl
  import insense_spi_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   csN,
  input  logic   sck,
  output strobeT strobes,
  output logic   active
);
  logic prevCs;
  logic prevSck;
  logic armed;
  logic csFall;
  logic sckRise;
  logic sckFall;

  assign csFall  = prevCs & ~csN;
  assign sckRise = ~prevSck & sck;
  assign sckFall = prevSck & ~sck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevCs  <= 1'b1;
      prevSck <= 1'b0;
      active  <= 1'b0;
      armed   <= 1'b0;
    end else begin
      prevCs  <= csN;
      prevSck <= sck;
      if (csN) begin
        active <= 1'b0;
        armed  <= 1'b0;
      end else if (csFall) begin
        active <= 1'b1;
        armed  <= 1'b0;
      end else if (active && sckRise) begin
        armed <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.load      = csFall;
    strobes.captureIn = active & ~csN & ~csFall & sckRise;
    strobes.shiftOut  = active & ~csN & ~csFall & armed & sckFall;
  end
endmodule

// File: rtl/insense_spi_datapath.sv
module insense_spi_datapath
  import insense_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inState,
  input  logic              uvAlarm,
  input  logic              otAlarm,
  input  logic              powerLost,
  input  logic              frameShort,
  input  logic              mosi,
  input  strobeT            strobes,
  output logic              misoBit
);
  localparam logic [DATA_W-1:0] GROUP_MASK [PAR_N] = '{8'hFF, 8'hF0, 8'h0F, 8'h3C};

  logic [DATA_W-1:0]  stateReg;
  logic [PAR_N-1:0]   parity;
  logic [FRAME_W-1:0] frameWord;
  logic [FRAME_W-1:0] shiftReg;
  logic               mosiHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateReg <= '0;
    else       stateReg <= inState;
  end

  for (genvar g = 0; g < PAR_N; g++) begin : gParity
    assign parity[g] = ^(stateReg & GROUP_MASK[g]);
  end

  always_comb begin
    frameWord                          = '0;
    frameWord[FRAME_W-1:CTRL_W]        = stateReg;
    frameWord[CTRL_W-1]                = ~uvAlarm;
    frameWord[CTRL_W-2]                = ~otAlarm;
    for (int g = 0; g < PAR_N; g++) begin
      frameWord[CTRL_W-3-g]            = parity[g];
    end
    frameWord[1]                       = 1'b0;
    frameWord[0]                       = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mosiHold <= 1'b0;
    end else begin
      if (strobes.captureIn) mosiHold <= mosi;
      if (strobes.load) begin
        shiftReg <= powerLost ? '0 : frameWord;
      end else if (strobes.shiftOut) begin
        if (frameShort)
          shiftReg <= {shiftReg[FRAME_W-2:CTRL_W], mosiHold, {CTRL_W{1'b0}}};
        else
          shiftReg <= {shiftReg[FRAME_W-2:0], mosiHold};
      end
    end
  end

  assign misoBit = shiftReg[FRAME_W-1] & ~powerLost;
endmodule

// File: rtl/insense_spi_frame.sv
module insense_spi_frame
  import insense_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inState,
  input  logic       uvAlarm,
  input  logic       otAlarm,
  input  logic       powerLost,
  input  logic       frameShort,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       misoN,
  output logic       misoEn
);
  strobeT strobes;
  logic   active;
  logic   misoBit;

  insense_spi_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck),
    .strobes(strobes), .active(active)
  );

  insense_spi_datapath i_dp (
    .clk(clk), .rstN(rstN), .inState(inState), .uvAlarm(uvAlarm),
    .otAlarm(otAlarm), .powerLost(powerLost), .frameShort(frameShort),
    .mosi(mosi), .strobes(strobes), .misoBit(misoBit)
  );

  assign misoEn = active;
  assign miso   = active & misoBit;
  assign misoN  = active & ~misoBit;
endmodule

// File: rtl/insense_spi_frame_chk.sv
module insense_spi_frame_chk (
  input logic clk,
  input logic rstN,
  input logic powerLost,
  input logic csN,
  input logic sck,
  input logic miso,
  input logic misoN,
  input logic misoEn
);
  AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (!misoEn && !miso && !misoN)); // R8

  AST_SELECT_ON: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && !csN) |=> misoEn); // R1

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    misoEn |-> (misoN == !miso)); // R10

  AST_POWER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    powerLost |-> !miso); // R9

  AST_HOLD_NO_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(csN) && !$past(csN, 2) && ($past(sck) == $past(sck, 2)) && $stable(powerLost))
      |-> $stable(miso)); // R4
endmodule

bind insense_spi_frame insense_spi_frame_chk i_chk (.*);

// File: tb/test_insense_spi_frame.sv
`timescale 1ns/1ps
module test_insense_spi_frame;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inState = '0;
  logic       uvAlarm = 1'b0;
  logic       otAlarm = 1'b0;
  logic       powerLost = 1'b0;
  logic       frameShort = 1'b0;
  logic       csN = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic       misoN;
  logic       misoEn;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic  expQ[$];
  string tagQ[$];
  event  sampleEv;

  always #2 clk = ~clk;

  insense_spi_frame i_insense_spi_frame (
    .clk(clk), .rstN(rstN), .inState(inState), .uvAlarm(uvAlarm),
    .otAlarm(otAlarm), .powerLost(powerLost), .frameShort(frameShort),
    .csN(csN), .sck(sck), .mosi(mosi),
    .miso(miso), .misoN(misoN), .misoEn(misoEn)
  );

  // monitor: pops expected items and compares against the outputs
  always @(sampleEv) begin
    logic  e;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    checks++;
    if (misoEn !== 1'b1 || miso !== e || misoN !== ~e) begin
      fails++;
      $display("FAIL %s: en=%b miso=%b misoN=%b expected en=1 miso=%b misoN=%b",
               t, misoEn, miso, misoN, e, ~e);
    end
  end

  task automatic pushSample(input logic e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    -> sampleEv;
    #0;
  endtask

  function automatic logic [15:0] refFrame(input logic [7:0] d, input logic uv, input logic ot);
    return {d, ~uv, ~ot, ^d, ^d[7:4], ^d[3:0], ^d[5:2], 1'b0, 1'b1};
  endfunction

  function automatic string posTag(input int i, input int len, input logic shortMode);
    if (i >= len) return shortMode ? "R6" : "R5";
    if (i < 8 || i == 8 || i == 9 || i == 14 || i == 15) return "R2";
    return "R3";
  endfunction

  task automatic runFrame(input logic [7:0] d, input logic uv, input logic ot,
                          input logic pl, input logic shortMode, input logic idleHigh,
                          input logic freeze, input logic [7:0] pat, input string tagAll);
    logic [15:0] f;
    int len;
    f   = pl ? 16'h0000 : refFrame(d, uv, ot);
    len = shortMode ? 8 : 16;
    inState = d; uvAlarm = uv; otAlarm = ot; powerLost = pl;
    frameShort = shortMode; sck = idleHigh; csN = 1'b1;
    repeat (3) @(negedge clk);
    csN = 1'b0;
    @(negedge clk);
    if (freeze) begin
      inState = ~d; uvAlarm = ~uv; otAlarm = ~ot;   // R11: must not reach the frame
    end
    pushSample(f[15], tagAll != "" ? tagAll : "R1");
    if (idleHigh) begin
      sck = 1'b0;                                   // R4: unqualified fall
      repeat (2) @(negedge clk);
      pushSample(f[15], "R4");
    end
    for (int i = 1; i <= len + 8; i++) begin
      logic e;
      mosi = pat[(i - 1) % 8];                      // R7: captured on rise i
      sck = 1'b1;
      repeat (2) @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
      if (pl)          e = 1'b0;
      else if (i < len) e = f[15 - i];
      else             e = pat[(i - len) % 8];
      pushSample(e, tagAll != "" ? tagAll : posTag(i, len, shortMode));
      @(negedge clk);
    end
    csN = 1'b1;
    sck = 1'b0;
    @(negedge clk);
    checks++;
    if (misoEn !== 1'b0 || miso !== 1'b0 || misoN !== 1'b0) begin
      fails++;
      $display("FAIL R8: en=%b miso=%b misoN=%b expected 0 0 0", misoEn, miso, misoN);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;                                       // R8 reset state
    if (misoEn !== 1'b0 || miso !== 1'b0 || misoN !== 1'b0) begin
      fails++;
      $display("FAIL R8: reset en=%b miso=%b misoN=%b expected 0 0 0", misoEn, miso, misoN);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R2 R3 R5 R7 R10: 16-bit frame, SCK low at select
    runFrame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'b1011_0010, "");
    // R4: SCK high at select, undervoltage active
    runFrame(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'b0110_1001, "");
    // R11: inputs flipped after capture, overtemperature active
    runFrame(8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'b1100_0011, "R11");
    // R6: 8-bit frame with pass-through
    runFrame(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'b1110_0100, "");
    // R9: supply lost, all zero
    runFrame(8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'b1111_1111, "R9");
    // R4 R6: 8-bit frame with SCK high at select
    runFrame(8'h17, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'b0101_0101, "");
    // R3: more parity patterns
    runFrame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'b0000_0001, "");
    runFrame(8'h24, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'b1000_0000, "");
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule